// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

A general-purpose I/O peripheral that sits on a simple single-cycle register bus and owns one GPIO line per register bit. Software sees five registers. A pin-level view returns the synchronised pad inputs. A set port and a clear port change the output latch with write-one semantics, so no read-modify-write is needed. An output-direction view and an input-direction view expose one shared direction state: one is always the bitwise inverse of the other. The block drives a per-line output enable and output value toward the pads.

Elaboration parameters choose the register width (8, 16, 32 or 64 bits, which is also the line count), whether line n appears at register bit (width-1-n), and whether the byte lanes of 16- and 32-bit accesses are swapped. A further parameter removes the clear port. The set port then becomes a plain output register that copies every written bit. Register offsets are counted in register-width units: 0 pin levels, 1 set, 2 clear, 3 direction-out, 4 direction-in.

Top module: `gpio_regblock`

## Requirements
- R1: While reset is high and on the first cycle after it, `pad_oe` and `pad_out` are all zero and `bus_rdata` is zero, so every line is an input and the latch is clear.
- R2: Offset 0 reads the pad levels through a two-flop synchroniser. A pad change made before clock edge k is returned by reads captured at edge k+2 and later. Reads captured at edges k and k+1 still return the old level. Lines driven as outputs also return their pad level.
- R3: With the clear port present, writing offset 1 sets each latch bit whose written bit is 1 and leaves every other bit unchanged.
- R4: With the clear port present, writing offset 2 clears each latch bit whose written bit is 1 and leaves every other bit unchanged. Offset 2 reads as zero.
- R5: Without the clear port, writing offset 1 copies every written bit, 1 or 0, into the latch. Offset 2 then reads zero, and writes to it are ignored.
- R6: Reading offset 1 returns the output latch, and `pad_out` always equals the latch.
- R7: Writing offset 3 loads the direction state, where 1 means output. Writing offset 4 loads its inverse, where 1 means input. Offset 4 always reads the inverse of offset 3, and `pad_oe` equals the direction state.
- R8: With mirrored order selected, line n maps to register bit (width-1-n) in every register, in both directions.
- R9: With byte swap selected at width 16 or 32, byte lane b of a register maps to lane (bytes-1-b). At width 8 or 64 the option has no effect.
- R10: Offsets 5 to 7 read zero, and writes to them change neither the latch nor the direction state.
- R11: `bus_rdata` is registered and updates only on the edge that captures a read access (`bus_sel` high, `bus_wr` low). Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register offset in width units |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data |
| pad_in | input | REG_W | Pad input levels, line order |
| pad_oe | output | REG_W | Per-line output enable |
| pad_out | output | REG_W | Per-line output value |

## Verification
The embedded properties assume that reset is asserted from the first clock edge. They also assume that the bus control inputs are never unknown outside reset, because the latch and direction properties treat any edge without a decoded strobe as idle. The stimulus holds reset for several cycles from time zero and changes every bus input only on the falling edge. It drops the strobe to zero between accesses, so each access covers exactly one rising edge. Pad inputs are changed on the falling edge as well; apart from that, the synchroniser timing check makes no assumption about them.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

    localparam int unsigned OFS_W = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_PINS = 3'd0,
        OFS_SET  = 3'd1,
        OFS_CLR  = 3'd2,
        OFS_DOUT = 3'd3,
        OFS_DIN  = 3'd4
    } gpio_ofs_e;

    typedef struct packed {
        logic set_we;
        logic clr_we;
        logic dout_we;
        logic din_we;
    } gpio_wr_s;

    function automatic gpio_wr_s decode_write(input logic wr_en,
                                              input logic [OFS_W-1:0] ofs,
                                              input logic has_clr);
        gpio_wr_s s;
        s.set_we  = wr_en && (ofs == OFS_SET);
        s.clr_we  = wr_en && has_clr && (ofs == OFS_CLR);
        s.dout_we = wr_en && (ofs == OFS_DOUT);
        s.din_we  = wr_en && (ofs == OFS_DIN);
        return s;
    endfunction

    function automatic bit swap_allowed(input int unsigned w);
        return (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

    // R2
    stage_order_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (sync_q == $past(meta_q)));
endmodule

// File: rtl/gpio_rb_lanemap.sv
module gpio_rb_lanemap #(
    parameter int unsigned W      = 32,
    parameter bit          MIRROR = 1'b0,
    parameter bit          SWAP   = 1'b0
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    localparam int unsigned NBYTES = W / 8;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int unsigned LANE = i / 8;
        localparam int unsigned POS  = i % 8;
        localparam int unsigned SIDX = SWAP ? (8 * (NBYTES - 1 - LANE) + POS) : i;
        localparam int unsigned MIDX = MIRROR ? (W - 1 - SIDX) : SIDX;
        assign dst[i] = src[MIDX];
    end
endmodule

// File: rtl/gpio_rb_core.sv
module gpio_rb_core
    import gpio_rb_pkg::*;
#(
    parameter int unsigned W       = 32,
    parameter bit          HAS_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  gpio_wr_s     wr,
    input  logic [W-1:0] wline,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] latch_d;
    logic [W-1:0] dir_d;

    always_comb begin
        latch_d = latch_q;
        if (wr.set_we) begin
            latch_d = HAS_CLR ? (latch_q | wline) : wline;
        end else if (wr.clr_we) begin
            latch_d = latch_q & ~wline;
        end
    end

    always_comb begin
        dir_d = dir_q;
        if (wr.dout_we) begin
            dir_d = wline;
        end else if (wr.din_we) begin
            dir_d = ~wline;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            dir_q   <= dir_d;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && dir_q == '0));

    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (wr == '0) |=> ($stable(latch_q) && $stable(dir_q)));

    // R7
    din_inverts_chk: assert property (@(posedge clk) disable iff (rst)
        wr.din_we |=> (dir_q == ~$past(wline)));

    if (HAS_CLR) begin : g_clr_chk
        // R3
        set_sets_chk: assert property (@(posedge clk) disable iff (rst)
            wr.set_we |=> ((latch_q & $past(wline)) == $past(wline)
                           && (latch_q & ~$past(wline)) == ($past(latch_q) & ~$past(wline))));
        // R4
        clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
            wr.clr_we |=> ((latch_q & $past(wline)) == '0
                           && (latch_q & ~$past(wline)) == ($past(latch_q) & ~$past(wline))));
    end else begin : g_plain_chk
        // R5
        plain_copy_chk: assert property (@(posedge clk) disable iff (rst)
            wr.set_we |=> (latch_q == $past(wline)));
    end
endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
    import gpio_rb_pkg::*;
#(
    parameter int unsigned REG_W     = 32,
    parameter bit          MIRROR    = 1'b0,
    parameter bit          BYTE_SWAP = 1'b0,
    parameter bit          HAS_CLR   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [REG_W-1:0] pad_in,
    output logic [REG_W-1:0] pad_oe,
    output logic [REG_W-1:0] pad_out
);
    localparam bit EFF_SWAP = BYTE_SWAP && swap_allowed(REG_W);

    logic [REG_W-1:0] wline;
    logic [REG_W-1:0] pins_sync;
    logic [REG_W-1:0] latch_q;
    logic [REG_W-1:0] dir_q;
    logic [REG_W-1:0] rd_line;
    logic [REG_W-1:0] rd_bus;
    gpio_wr_s         wr;
    logic             rd_en;

    assign wr    = decode_write(bus_sel && bus_wr, bus_addr, HAS_CLR);
    assign rd_en = bus_sel && !bus_wr;

    gpio_rb_lanemap #(.W(REG_W), .MIRROR(MIRROR), .SWAP(EFF_SWAP)) u_wmap (
        .src (bus_wdata),
        .dst (wline)
    );

    gpio_rb_sync #(.W(REG_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    gpio_rb_core #(.W(REG_W), .HAS_CLR(HAS_CLR)) u_core (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wline   (wline),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    always_comb begin
        case (bus_addr)
            OFS_PINS: rd_line = pins_sync;
            OFS_SET:  rd_line = latch_q;
            OFS_DOUT: rd_line = dir_q;
            OFS_DIN:  rd_line = ~dir_q;
            default:  rd_line = '0;
        endcase
    end

    gpio_rb_lanemap #(.W(REG_W), .MIRROR(MIRROR), .SWAP(EFF_SWAP)) u_rmap (
        .src (rd_line),
        .dst (rd_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_bus;
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = latch_q;

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_rdata));

    // R10
    undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_addr > 3'd4) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_regblock_test.sv
`timescale 1ns/1ps
module gpio_regblock_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_s = 1'b0;
    logic [2:0]  addr_s = 3'd0;
    logic [63:0] wd_s = '0;
    logic        sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic [31:0] pad_a = '0;
    logic [15:0] pad_b = '0;
    logic [7:0]  pad_c = '0;
    logic [31:0] rd_a, oe_a, out_a;
    logic [15:0] rd_b, oe_b, out_b;
    logic [7:0]  rd_c, oe_c, out_c;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // 32-bit, clear port present, natural order
    gpio_regblock #(.REG_W(32), .MIRROR(1'b0), .BYTE_SWAP(1'b0), .HAS_CLR(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_sel(sel_a), .bus_wr(wr_s), .bus_addr(addr_s),
        .bus_wdata(wd_s[31:0]), .bus_rdata(rd_a), .pad_in(pad_a), .pad_oe(oe_a), .pad_out(out_a));

    // 16-bit, mirrored, byte swapped, no clear port
    gpio_regblock #(.REG_W(16), .MIRROR(1'b1), .BYTE_SWAP(1'b1), .HAS_CLR(1'b0)) uut_b (
        .clk(clk), .rst(rst), .bus_sel(sel_b), .bus_wr(wr_s), .bus_addr(addr_s),
        .bus_wdata(wd_s[15:0]), .bus_rdata(rd_b), .pad_in(pad_b), .pad_oe(oe_b), .pad_out(out_b));

    // 8-bit, byte swap requested (no effect at this width)
    gpio_regblock #(.REG_W(8), .MIRROR(1'b0), .BYTE_SWAP(1'b1), .HAS_CLR(1'b1)) uut_c (
        .clk(clk), .rst(rst), .bus_sel(sel_c), .bus_wr(wr_s), .bus_addr(addr_s),
        .bus_wdata(wd_s[7:0]), .bus_rdata(rd_c), .pad_in(pad_c), .pad_oe(oe_c), .pad_out(out_c));

    // scoreboard queues
    logic [63:0] exp_q[$];
    int          inst_q[$];
    string       tag_q[$];

    logic rd_pend = 1'b0;
    int   rd_inst = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pick(input int inst);
        case (inst)
            0: return {32'd0, rd_a};
            1: return {48'd0, rd_b};
            default: return {56'd0, rd_c};
        endcase
    endfunction

    always @(posedge clk) begin
        rd_pend <= (sel_a || sel_b || sel_c) && !wr_s && !rst;
        rd_inst <= sel_a ? 0 : (sel_b ? 1 : 2);
    end

    // monitor
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R11 unexpected read response actual=%h expected=none", pick(rd_inst));
            end else begin
                check(tag_q.pop_front(), pick(inst_q.pop_front()), exp_q.pop_front());
            end
        end
    end

    // called at a falling edge; returns at the next falling edge
    task automatic bus_write(input int inst, input logic [2:0] a, input logic [63:0] d);
        wr_s = 1'b1; addr_s = a; wd_s = d;
        sel_a = (inst == 0); sel_b = (inst == 1); sel_c = (inst == 2);
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0; wr_s = 1'b0;
    endtask

    task automatic bus_read(input int inst, input logic [2:0] a, input logic [63:0] exp, input string tag);
        exp_q.push_back(exp); inst_q.push_back(inst); tag_q.push_back(tag);
        wr_s = 1'b0; addr_s = a;
        sel_a = (inst == 0); sel_b = (inst == 1); sel_c = (inst == 2);
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 pad_oe after reset", {32'd0, oe_a}, 64'd0);
        check("R1 pad_out after reset", {32'd0, out_a}, 64'd0);
        check("R1 rdata after reset", {32'd0, rd_a}, 64'd0);
        bus_read(0, 3'd1, 64'd0, "R1 set reads zero after reset");
        bus_read(0, 3'd4, 64'hFFFF_FFFF, "R1 all lines input after reset");

        // R3 set with write-one semantics
        bus_write(0, 3'd1, 64'h0000_00F0);
        check("R3 set first", {32'd0, out_a}, 64'h0000_00F0);
        bus_write(0, 3'd1, 64'h0F00_0001);
        check("R3 set merges", {32'd0, out_a}, 64'h0F00_00F1);
        bus_read(0, 3'd1, 64'h0F00_00F1, "R6 set readback");

        // R4 clear
        bus_write(0, 3'd2, 64'h0000_0030);
        check("R4 clear bits", {32'd0, out_a}, 64'h0F00_00C1);
        bus_read(0, 3'd2, 64'd0, "R4 clear reads zero");
        bus_read(0, 3'd1, 64'h0F00_00C1, "R6 latch after clear");

        // R7 direction views
        bus_write(0, 3'd3, 64'h0000_FFFF);
        check("R7 oe from dirout", {32'd0, oe_a}, 64'h0000_FFFF);
        bus_read(0, 3'd4, 64'hFFFF_0000, "R7 dirin is inverse");
        bus_write(0, 3'd4, 64'h0000_00FF);
        check("R7 oe from dirin", {32'd0, oe_a}, 64'hFFFF_FF00);
        bus_read(0, 3'd3, 64'hFFFF_FF00, "R7 dirout after dirin write");

        // R10 undefined offsets
        bus_write(0, 3'd5, 64'hFFFF_FFFF);
        bus_write(0, 3'd7, 64'h0000_0000);
        check("R10 latch untouched", {32'd0, out_a}, 64'h0F00_00C1);
        check("R10 direction untouched", {32'd0, oe_a}, 64'hFFFF_FF00);
        bus_read(0, 3'd5, 64'd0, "R10 offset 5 reads zero");
        bus_read(0, 3'd6, 64'd0, "R10 offset 6 reads zero");
        bus_read(0, 3'd7, 64'd0, "R10 offset 7 reads zero");

        // R2 synchroniser timing
        pad_a = 32'h0000_1234;
        idle(3);
        bus_read(0, 3'd0, 64'h0000_1234, "R2 settled pad level");
        pad_a = 32'hA5A5_0000;
        bus_read(0, 3'd0, 64'h0000_1234, "R2 old level at edge k");
        bus_read(0, 3'd0, 64'h0000_1234, "R2 old level at edge k+1");
        bus_read(0, 3'd0, 64'hA5A5_0000, "R2 new level at edge k+2 incl. output lines");

        // R11 rdata holds without a read
        bus_write(0, 3'd1, 64'hFFFF_FFFF);
        idle(2);
        check("R11 rdata held", {32'd0, rd_a}, 64'hA5A5_0000);

        // R8 / R9 mirrored and swapped 16-bit instance, R5 plain output
        bus_write(1, 3'd3, 64'h0001);
        check("R8 R9 bus bit0 drives line 7 enable", {48'd0, oe_b}, 64'h0080);
        bus_write(1, 3'd1, 64'h0001);
        check("R8 R9 set maps to line 7", {48'd0, out_b}, 64'h0080);
        bus_write(1, 3'd1, 64'h0300);
        check("R5 plain copy replaces latch", {48'd0, out_b}, 64'hC000);
        bus_write(1, 3'd2, 64'hFFFF);
        check("R5 offset 2 write ignored", {48'd0, out_b}, 64'hC000);
        bus_read(1, 3'd2, 64'd0, "R5 offset 2 reads zero");
        bus_read(1, 3'd1, 64'h0300, "R8 R9 set readback round trip");
        bus_read(1, 3'd4, 64'hFFFE, "R8 R7 dirin inverse mapped");
        pad_b = 16'h0001;
        idle(3);
        bus_read(1, 3'd0, 64'h0080, "R8 R9 pad line 0 read position");

        // R9 no effect at 8 bits
        bus_write(2, 3'd1, 64'h01);
        check("R9 8-bit set unswapped", {56'd0, out_c}, 64'h01);
        pad_c = 8'h5A;
        idle(3);
        bus_read(2, 3'd0, 64'h5A, "R9 8-bit pins unswapped");

        idle(3);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R11 missing read responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule